// File: doc/BRIEF.md
# Embedded-Boundary Deserializer with Word Clock

This block receives a forwarded bit clock and a serial data line and rebuilds parallel words from them. The words carry no separate framing signal. The end of each word is marked inside the clock stream: one low pulse of the forwarded clock is left out, so the clock stays high for roughly two and a half to three bit times. The two extra bits sent during that long high interval always toggle the data line. The block samples the line on a fast local clock, at least four samples per bit. It recovers the clock edges by synchronizing and edge-detecting the line, and it measures the bit period by counting local cycles between ordinary falling edges.

When a valid boundary ends, the block delivers the 24 bits captured before it. The two boundary bits never reach the outputs. Twenty payload bits go to the parallel port and two bits go to a pair of dedicated outputs, while the top two bits are dropped. An active-low word clock pulse of fixed shape follows each accepted word, and its timing is derived from the measured bit period. A boundary that carries no data transition, or that arrives before a full word has been received, counts as a framing error and is otherwise ignored.

Top module: `bdrx_deser`

## Requirements
- R1: After reset, `pay_o` and `ded_o` are all zero, `wclk_n_o` is 1 and `frame_err_cnt_o` is 0. These values hold until the first valid word is accepted.
- R2: The bit period is the number of `clk` cycles between two ordinary falling edges of `ser_clk_i` (at least 4). A high interval of `ser_clk_i` is a boundary only if it lasts at least 2 measured periods. Shorter high intervals, including stretched ones, are ordinary bits.
- R3: Data is sampled at each rising edge of `ser_clk_i`. The word is formed from the 24 samples taken just before a boundary, and the earliest of these is word bit 0. Filler bits sent earlier are ignored.
- R4: On acceptance, `pay_o[k]` takes word bit k for k = 0..19, `ded_o[0]` takes word bit 20 and `ded_o[1]` takes word bit 21. Word bits 22 and 23 are discarded.
- R5: `wclk_n_o` falls 6 measured bit periods after the falling edge of `ser_clk_i` that ends a valid boundary. Input synchronization adds a few cycles to this delay.
- R6: `wclk_n_o` then stays low for exactly 13 measured bit periods and returns high. It stays high until the next valid word.
- R7: The outputs take the new word two `clk` cycles before `wclk_n_o` falls, and they do not change while `wclk_n_o` is low.
- R8: While no boundary arrives, `wclk_n_o` stays high and the outputs keep their values.
- R9: A boundary is dropped if the data line does not change during its high interval, or if fewer than 24 bits were sampled since the previous boundary or reset. A dropped boundary changes no output, produces no pulse, and raises `frame_err_cnt_o` by one (saturating).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Forwarded bit clock with embedded boundary (asynchronous) |
| ser_dat_i | input | 1 | Serial data line (asynchronous) |
| pay_o | output | 20 | Parallel payload word bits 0..19 |
| ded_o | output | 2 | Dedicated outputs, word bits 20 and 21 |
| wclk_n_o | output | 1 | Active-low word clock pulse |
| frame_err_cnt_o | output | 8 | Saturating count of dropped boundaries |

## Verification
The hardest case to reach is a high interval that is long but still not a boundary. It has to appear after a period has been measured, and it must not disturb either that measurement or the word being received. The bench stretches one high half-bit in the middle of a word to 1.5 periods and then checks that the word still decodes intact with no error. A second hard case is a short word that follows a valid boundary so closely that the previous word clock pulse is still running. To create it, the bench sends ten bits and a boundary with no filler in between, so that the bit count has had no chance to saturate.

// File: rtl/bdrx_pkg.sv
`timescale 1ns/1ps
package bdrx_pkg;
    localparam int unsigned WORD_BITS = 24;
    localparam int unsigned PAY_BITS  = 20;
    localparam int unsigned DED_BITS  = 2;
    localparam int unsigned CAP_BITS  = PAY_BITS + DED_BITS;

    typedef struct packed {
        logic [DED_BITS-1:0] ded;
        logic [PAY_BITS-1:0] pay;
    } rx_word_t;

    typedef enum logic [1:0] {
        WC_IDLE  = 2'd0,
        WC_DELAY = 2'd1,
        WC_LOW   = 2'd2
    } wc_state_e;

    function automatic logic [31:0] mul_k(input logic [31:0] a, input logic [31:0] k);
        return a * k;
    endfunction
endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_edge_sync.sv
`timescale 1ns/1ps
module rx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic lvl;
    logic prev;

    rx_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_i),
        .q   (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign lvl_o  = lvl;
    assign rise_o = lvl & ~prev;
    assign fall_o = ~lvl & prev;
endmodule

// File: rtl/rx_frame_det.sv
`timescale 1ns/1ps
module rx_frame_det import bdrx_pkg::*; #(
    parameter int CNT_W    = 10,
    parameter int MIN_OSR  = 4,
    parameter int BND_MULT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ck_lvl,
    input  logic                ck_rise,
    input  logic                ck_fall,
    input  logic                dat_lvl,
    output logic                bnd_ok,
    output logic                bnd_err,
    output rx_word_t            word_o,
    output logic [CNT_W-1:0]    period_o
);
    localparam int NB_W = $clog2(WORD_BITS + 1);

    logic [CNT_W-1:0]     fall_cnt;
    logic [CNT_W-1:0]     hi_cnt;
    logic [CNT_W-1:0]     period;
    logic                 per_ok;
    logic                 seen_fall;
    logic                 ref_bit;
    logic                 trans_seen;
    logic [WORD_BITS-1:0] shreg;
    logic [NB_W-1:0]      nbits;
    rx_word_t             word_q;
    logic                 is_long;
    logic                 full;

    assign is_long = per_ok && (32'(hi_cnt) >= mul_k(32'(period), 32'(BND_MULT)));
    assign full    = (nbits == NB_W'(WORD_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_cnt   <= '0;
            hi_cnt     <= '0;
            period     <= '0;
            per_ok     <= 1'b0;
            seen_fall  <= 1'b0;
            ref_bit    <= 1'b0;
            trans_seen <= 1'b0;
            shreg      <= '0;
            nbits      <= '0;
            word_q     <= '0;
            bnd_ok     <= 1'b0;
            bnd_err    <= 1'b0;
        end else begin
            bnd_ok  <= 1'b0;
            bnd_err <= 1'b0;
            if (ck_fall)               fall_cnt <= CNT_W'(1);
            else if (fall_cnt != '1)   fall_cnt <= fall_cnt + 1'b1;

            if (ck_rise) begin
                shreg      <= {dat_lvl, shreg[WORD_BITS-1:1]};
                ref_bit    <= dat_lvl;
                trans_seen <= 1'b0;
                hi_cnt     <= CNT_W'(1);
                if (!full) nbits <= nbits + 1'b1;
            end else if (ck_lvl) begin
                if (hi_cnt != '1)       hi_cnt <= hi_cnt + 1'b1;
                if (dat_lvl != ref_bit) trans_seen <= 1'b1;
            end

            if (ck_fall) begin
                seen_fall <= 1'b1;
                if (is_long) begin
                    nbits <= '0;
                    if (trans_seen && full) begin
                        bnd_ok <= 1'b1;
                        word_q <= rx_word_t'(shreg[CAP_BITS-1:0]);
                    end else begin
                        bnd_err <= 1'b1;
                    end
                end else if (seen_fall && fall_cnt >= CNT_W'(MIN_OSR)) begin
                    period <= fall_cnt;
                    per_ok <= 1'b1;
                end
            end
        end
    end

    assign word_o   = word_q;
    assign period_o = period;

    a_r9_ok_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(bnd_ok && bnd_err));
    a_r2_bnd_after_fall: assert property (@(posedge clk) disable iff (rst)
        (bnd_ok || bnd_err) |-> $past(ck_fall));
endmodule

// File: rtl/rx_wclk_gen.sv
`timescale 1ns/1ps
module rx_wclk_gen import bdrx_pkg::*; #(
    parameter int CNT_W    = 10,
    parameter int DLY_BITS = 6,
    parameter int LOW_BITS = 13,
    parameter int LEAD     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CNT_W-1:0]    period,
    input  rx_word_t            word_i,
    output logic [PAY_BITS-1:0] pay_o,
    output logic [DED_BITS-1:0] ded_o,
    output logic                wclk_n_o
);
    localparam int TW = CNT_W + 5;

    wc_state_e     state;
    logic [TW-1:0] cnt;
    rx_word_t      hold;
    rx_word_t      out_q;
    logic          wclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WC_IDLE;
            cnt    <= '0;
            hold   <= '0;
            out_q  <= '0;
            wclk_q <= 1'b1;
        end else if (start) begin
            hold   <= word_i;
            state  <= WC_DELAY;
            cnt    <= TW'(mul_k(32'(period), 32'(DLY_BITS)) - 32'd1);
            wclk_q <= 1'b1;
        end else begin
            case (state)
                WC_DELAY: begin
                    if (cnt == TW'(LEAD)) out_q <= hold;
                    if (cnt == '0) begin
                        state  <= WC_LOW;
                        wclk_q <= 1'b0;
                        cnt    <= TW'(mul_k(32'(period), 32'(LOW_BITS)) - 32'd1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                WC_LOW: begin
                    if (cnt == '0) begin
                        state  <= WC_IDLE;
                        wclk_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= WC_IDLE;
            endcase
        end
    end

    assign pay_o    = out_q.pay;
    assign ded_o    = out_q.ded;
    assign wclk_n_o = wclk_q;

    a_r1_reset_vals: assert property (@(posedge clk)
        $past(rst) |-> (out_q == '0 && wclk_q));
    a_r7_stable_low: assert property (@(posedge clk) disable iff (rst)
        !wclk_q |-> $stable(out_q));
    a_r6_fall_from_delay: assert property (@(posedge clk) disable iff (rst)
        $fell(wclk_q) |-> $past(state) == WC_DELAY);
    a_r8_delay_needs_start: assert property (@(posedge clk) disable iff (rst)
        (state == WC_DELAY && $past(state) != WC_DELAY) |-> $past(start));
endmodule

// File: rtl/bdrx_deser.sv
`timescale 1ns/1ps
module bdrx_deser import bdrx_pkg::*; #(
    parameter int CNT_W       = 10,
    parameter int ERR_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_OSR     = 4,
    parameter int BND_MULT    = 2,
    parameter int DLY_BITS    = 6,
    parameter int LOW_BITS    = 13,
    parameter int LEAD        = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk_i,
    input  logic                ser_dat_i,
    output logic [PAY_BITS-1:0] pay_o,
    output logic [DED_BITS-1:0] ded_o,
    output logic                wclk_n_o,
    output logic [ERR_W-1:0]    frame_err_cnt_o
);
    logic             ck_lvl, ck_rise, ck_fall;
    logic             dat_lvl;
    logic             bnd_ok, bnd_err;
    rx_word_t         word;
    logic [CNT_W-1:0] period;
    logic [ERR_W-1:0] err_cnt;

    rx_edge_sync #(.STAGES(SYNC_STAGES)) u_ck (
        .clk    (clk),
        .rst    (rst),
        .line_i (ser_clk_i),
        .lvl_o  (ck_lvl),
        .rise_o (ck_rise),
        .fall_o (ck_fall)
    );

    rx_sync #(.STAGES(SYNC_STAGES)) u_dat (
        .clk (clk),
        .rst (rst),
        .d   (ser_dat_i),
        .q   (dat_lvl)
    );

    rx_frame_det #(.CNT_W(CNT_W), .MIN_OSR(MIN_OSR), .BND_MULT(BND_MULT)) u_det (
        .clk      (clk),
        .rst      (rst),
        .ck_lvl   (ck_lvl),
        .ck_rise  (ck_rise),
        .ck_fall  (ck_fall),
        .dat_lvl  (dat_lvl),
        .bnd_ok   (bnd_ok),
        .bnd_err  (bnd_err),
        .word_o   (word),
        .period_o (period)
    );

    rx_wclk_gen #(.CNT_W(CNT_W), .DLY_BITS(DLY_BITS), .LOW_BITS(LOW_BITS), .LEAD(LEAD)) u_wclk (
        .clk      (clk),
        .rst      (rst),
        .start    (bnd_ok),
        .period   (period),
        .word_i   (word),
        .pay_o    (pay_o),
        .ded_o    (ded_o),
        .wclk_n_o (wclk_n_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                          err_cnt <= '0;
        else if (bnd_err && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
    end

    assign frame_err_cnt_o = err_cnt;

    a_r9_err_only_on_drop: assert property (@(posedge clk) disable iff (rst)
        !$past(bnd_err) |-> $stable(err_cnt));
endmodule

// File: tb/bdrx_deser_bench.sv
`timescale 1ns/1ps
module bdrx_deser_bench;
    localparam int P = 8;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic [19:0] pay;
    logic [1:0]  ded;
    logic        wclk_n;
    logic [7:0]  err;

    bdrx_deser u_bdrx_deser (
        .clk             (clk),
        .rst             (rst),
        .ser_clk_i       (ser_clk),
        .ser_dat_i       (ser_dat),
        .pay_o           (pay),
        .ded_o           (ded),
        .wclk_n_o        (wclk_n),
        .frame_err_cnt_o (err)
    );

    always #2.5 clk = ~clk;

    // bit 24 = boundary carries a transition, bits 23:0 = word
    localparam logic [24:0] VEC [8] = '{
        25'h1C3A5F1, 25'h1155555, 25'h13FFFFF, 25'h00F0F0F,
        25'h1800001, 25'h14ABCDE, 25'h0FFFFFF, 25'h1000000
    };

    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    int          fall_cyc = 0;
    int          low_start = 0;
    int          pulses = 0;
    bit          mark = 1'b0;
    bit          done = 1'b0;
    logic        w_prev = 1'b1;
    logic [21:0] h1 = '0;
    logic [21:0] h2 = '0;
    logic [21:0] low_val = '0;
    logic [21:0] exp_out = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (w_prev && !wclk_n) begin
                pulses++;
                chk((cyc - fall_cyc) >= 46 && (cyc - fall_cyc) <= 58, "R5 fall delay",
                    32'(cyc - fall_cyc), 32'(6*P));
                chk(h2 == exp_out, "R7 data two cycles early", 32'(h2), 32'(exp_out));
                chk({ded, pay} == exp_out, "R4 word mapping", 32'({ded, pay}), 32'(exp_out));
                low_start = cyc;
                low_val = {ded, pay};
            end
            if (!wclk_n && {ded, pay} != low_val)
                chk(1'b0, "R7 stable while low", 32'({ded, pay}), 32'(low_val));
            if (!w_prev && wclk_n)
                chk((cyc - low_start) >= 103 && (cyc - low_start) <= 105, "R6 low width",
                    32'(cyc - low_start), 32'(13*P));
        end
        h2 = h1;
        h1 = {ded, pay};
        w_prev = wclk_n;
    end

    task automatic drive(input bit c, input bit d, input int n);
        repeat (n) begin
            @(negedge clk);
            if (mark && ser_clk && !c) begin
                fall_cyc = cyc;
                mark = 1'b0;
            end
            ser_clk = c;
            ser_dat = d;
        end
    endtask

    task automatic send_bit(input bit d, input int hi);
        drive(1'b0, d, P - H);
        drive(1'b1, d, hi);
    endtask

    task automatic idle(input int n);
        repeat (n) send_bit(1'b0, H);
    endtask

    task automatic send_word(input logic [23:0] w, input bit good, input int nb, input int st);
        for (int i = 0; i < nb; i++) send_bit(w[i], (i == st) ? (P + H) : H);
        if (good) begin
            drive(1'b1, ~w[nb-1], P);
            drive(1'b1, w[nb-1], P);
        end else begin
            drive(1'b1, w[nb-1], 2*P);
        end
        mark = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1-related run hung act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_pulses = 0;
        int exp_err = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pay == '0, "R1 payload after reset", 32'(pay), 0);
        chk(ded == '0, "R1 dedicated after reset", 32'(ded), 0);
        chk(wclk_n == 1'b1, "R1 word clock after reset", 32'(wclk_n), 1);
        chk(err == '0, "R1 error count after reset", 32'(err), 0);

        // R8 idle stream, no boundary
        idle(40);
        chk(pulses == 0, "R8 no pulse without boundary", 32'(pulses), 0);
        chk({ded, pay} == '0, "R1 outputs low until first word", 32'({ded, pay}), 0);

        // vector table: R3 R4 R9
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][24]) begin
                exp_out = VEC[i][21:0];
                exp_pulses++;
            end else begin
                exp_err++;
            end
            send_word(VEC[i][23:0], VEC[i][24], 24, -1);
            idle(30);
            chk(pulses == exp_pulses, "R9 pulse count", 32'(pulses), 32'(exp_pulses));
            chk(int'(err) == exp_err, "R9 error count", 32'(err), 32'(exp_err));
            chk({ded, pay} == exp_out, "R4 held output", 32'({ded, pay}), 32'(exp_out));
        end

        // R2 stretched high half-bit is an ordinary bit
        exp_out = 22'h2D3C1B;
        exp_pulses++;
        send_word(24'h6D3C1B, 1'b1, 24, 5);
        idle(30);
        chk(pulses == exp_pulses, "R2 stretched bit keeps word", 32'(pulses), 32'(exp_pulses));
        chk(int'(err) == exp_err, "R2 stretched bit no error", 32'(err), 32'(exp_err));
        chk({ded, pay} == exp_out, "R2 stretched word value", 32'({ded, pay}), 32'(exp_out));

        // R9 short word right after a boundary
        exp_out = 22'h1234AB;
        exp_pulses++;
        exp_err++;
        send_word(24'h1234AB, 1'b1, 24, -1);
        send_word(24'h0003A5, 1'b1, 10, -1);
        idle(30);
        chk(pulses == exp_pulses, "R9 short word no pulse", 32'(pulses), 32'(exp_pulses));
        chk(int'(err) == exp_err, "R9 short word counted", 32'(err), 32'(exp_err));
        chk({ded, pay} == exp_out, "R9 short word dropped", 32'({ded, pay}), 32'(exp_out));

        // R3 word after long filler run
        exp_out = 22'h0A5A5A;
        exp_pulses++;
        idle(60);
        send_word(24'hCA5A5A, 1'b1, 24, -1);
        idle(30);
        chk({ded, pay} == exp_out, "R3 last 24 bits form word", 32'({ded, pay}), 32'(exp_out));
        chk(wclk_n == 1'b1, "R6 word clock back high", 32'(wclk_n), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule